// File: doc/BRIEF.md
# Background DAC Mismatch Noise Canceller

This block removes the noise that a dynamically scrambled multi-element DAC injects into a pipelined converter's output. The scrambler drives each of its switching blocks with a known pseudo-random code that takes the values -1, 0 or +1. The injected noise is the sum of these codes, each scaled by an unknown constant mismatch. The block treats each code as a spreading sequence. It coarsely requantizes the digitized residue of the later stages, using dither so that the requantization error stays uncorrelated. It then averages the product of that level with each code to estimate the matching mismatch constant. The rebuilt noise, the sum of each code times its estimate, is subtracted from the uncorrected converter word.

The codes arrive before the residue that they affect. A register line that advances once per valid sample delays them, so that each code meets its own residue. Each estimate comes from a block average over a power-of-two number of non-zero code samples. A freeze input halts learning while keeping the correction active.

Top module: `dnc_canceller`

## Requirements
- R1: While reset is active, `out_valid_o`, `corr_o` and every estimate are zero.
- R2: The residue level is floor((residue_i + dither_i) / 2^QSH), clamped to the range -3..+3. Here residue_i is two's complement and dither_i is an unsigned QSH-bit value.
- R3: Code k sits at `code_i[2k+1:2k]`. The value 01 means +1 and 11 means -1. Both 00 and 10 mean 0.
- R4: The code vector presented with valid sample n is paired with the residue and uncorrected word of valid sample n+CODE_LAT. The first CODE_LAT samples after reset pair with all-zero codes. Codes presented while `in_valid` is low have no effect.
- R5: Correlator k changes only on a valid sample whose paired code k is non-zero while `freeze_i` is low. It then adds code times level to its sum and increments its sample count.
- R6: On the 2^AVG_LOG-th counted update of a block, estimate k becomes floor(sum * 2^QSH / 2^AVG_LOG), and the sum and count restart from zero. Estimate k is the signed EST_W-bit field `est_o[k*EST_W +: EST_W]` with EST_W = QSH+3. It is visible one cycle after that sample.
- R7: While `freeze_i` is high, no sum or count moves and all estimates hold. Correction continues with the held estimates.
- R8: One cycle after each valid sample, `out_valid_o` is high. At that point `corr_o` equals uncorr_i minus the sum over k of paired code k times estimate k, wrapped to OUT_W bits. The estimates used are those held before that sample.
- R9: `out_valid_o` is low, and `corr_o` holds its value, one cycle after every cycle in which `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| residue_i | input | RES_W (14) | Signed digitized residue of the later stages |
| uncorr_i | input | OUT_W (16) | Signed uncorrected converter word |
| code_i | input | 2*NSEQ (18) | Ternary selection codes, two bits per block |
| dither_i | input | QSH (11) | Unsigned pseudo-random dither |
| freeze_i | input | 1 | Halt estimate learning |
| out_valid_o | output | 1 | Corrected word strobe |
| corr_o | output | OUT_W (16) | Signed corrected word |
| est_o | output | NSEQ*(QSH+3) (126) | Signed mismatch estimates, block k at field k |

## Verification
A valid sample's corrected word and strobe are due exactly one clock after the rising edge that takes that sample. An estimate finished by a sample is visible at that same point. A code vector first affects the output CODE_LAT valid samples later, however many idle cycles lie between them. The bench drives inputs at the falling edge. It advances its behavioural model by one clock for each rising edge. It compares every output at the next falling edge, so each result is read in the cycle its latency places it. Directed checks read estimates after counted sample totals that lie one short of a block boundary and exactly on it.

// File: rtl/dnc_pkg.sv
package dnc_pkg;
   typedef enum logic [1:0] {
      TC_ZERO  = 2'b00,
      TC_POS   = 2'b01,
      TC_ZERO2 = 2'b10,
      TC_NEG   = 2'b11
   } tern_e;

   function automatic logic tern_nonzero(input logic [1:0] c);
      return c[0];
   endfunction
endpackage

// File: rtl/dnc_code_delay.sv
module dnc_code_delay #(
   parameter int W   = 18,
   parameter int LAT = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv_i,
   input  logic [W-1:0] code_i,
   output logic [W-1:0] code_o
);
   if (W < 2) begin : g_bad_w
      $error("dnc_code_delay: W must be at least 2");
   end
   if (LAT < 0) begin : g_bad_lat
      $error("dnc_code_delay: LAT must not be negative");
   end

   if (LAT == 0) begin : g_thru
      assign code_o = code_i;
   end else begin : g_pipe
      logic [W-1:0] stg [LAT];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < LAT; i++) stg[i] <= '0;
         end else if (adv_i) begin
            stg[0] <= code_i;
            for (int i = 1; i < LAT; i++) stg[i] <= stg[i-1];
         end
      end
      assign code_o = stg[LAT-1];

      // R4: codes move only on valid samples
      p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !adv_i |=> $stable(code_o));
   end
endmodule

// File: rtl/dnc_requant.sv
module dnc_requant #(
   parameter int RES_W = 14,
   parameter int QSH   = 11
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic signed [RES_W-1:0] res_i,
   input  logic        [QSH-1:0]   dith_i,
   output logic signed [2:0]       lvl_o
);
   localparam int SW = RES_W + 1;
   localparam int LW = SW - QSH;

   if (QSH < 1 || QSH >= RES_W) begin : g_bad_qsh
      $error("dnc_requant: QSH must lie in 1..RES_W-1");
   end

   logic signed [SW-1:0] sum_w;
   logic signed [SW-1:0] shf_w;
   logic signed [LW-1:0] lvl_raw;

   assign sum_w   = SW'(res_i) + SW'($signed({1'b0, dith_i}));
   assign shf_w   = sum_w >>> QSH;
   assign lvl_raw = shf_w[LW-1:0];

   if (LW < 3) begin : g_noclamp
      assign lvl_o = 3'(lvl_raw);
   end else begin : g_clamp
      localparam logic signed [LW-1:0] LMAX = LW'(3);
      localparam logic signed [LW-1:0] LMIN = -LW'(3);
      always_comb begin
         if (lvl_raw > LMAX)      lvl_o = 3'sd3;
         else if (lvl_raw < LMIN) lvl_o = -3'sd3;
         else                     lvl_o = lvl_raw[2:0];
      end
   end

   // R2: level confined to the seven allowed values
   p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_o != -3'sd4));
endmodule

// File: rtl/dnc_corr.sv
module dnc_corr
   import dnc_pkg::*;
#(
   parameter int QSH     = 11,
   parameter int AVG_LOG = 4,
   parameter int EST_W   = 14
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valid_i,
   input  logic                    freeze_i,
   input  logic [1:0]              code_i,
   input  logic signed [2:0]       lvl_i,
   output logic signed [EST_W-1:0] est_o
);
   localparam int ACC_W = AVG_LOG + 3;
   localparam int WW    = ACC_W + QSH;

   if (AVG_LOG < 1) begin : g_bad_avg
      $error("dnc_corr: AVG_LOG must be at least 1");
   end
   if (EST_W < QSH + 3) begin : g_bad_est
      $error("dnc_corr: EST_W too narrow for the estimate range");
   end

   logic signed [ACC_W-1:0] acc, acc_nxt, prod;
   logic        [AVG_LOG-1:0] cnt;
   logic                      upd, last;
   logic signed [WW-1:0]      wide, scaled;

   always_comb begin
      case (tern_e'(code_i))
         TC_POS:  prod = ACC_W'(lvl_i);
         TC_NEG:  prod = -ACC_W'(lvl_i);
         default: prod = '0;
      endcase
   end

   assign upd     = valid_i && !freeze_i && tern_nonzero(code_i);
   assign acc_nxt = acc + prod;
   assign last    = &cnt;
   assign wide    = WW'(acc_nxt) <<< QSH;
   assign scaled  = wide >>> AVG_LOG;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc   <= '0;
         cnt   <= '0;
         est_o <= '0;
      end else if (upd) begin
         if (last) begin
            est_o <= scaled[EST_W-1:0];
            acc   <= '0;
            cnt   <= '0;
         end else begin
            acc <= acc_nxt;
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R7: no learning while frozen
   p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_i |=> ($stable(est_o) && $stable(acc) && $stable(cnt)));
   // R5: a zero code leaves the correlator untouched
   p_zero_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tern_nonzero(code_i) |=> ($stable(acc) && $stable(cnt)));
endmodule

// File: rtl/dnc_canceller.sv
module dnc_canceller
   import dnc_pkg::*;
#(
   parameter int NSEQ     = 9,
   parameter int RES_W    = 14,
   parameter int OUT_W    = 16,
   parameter int QSH      = 11,
   parameter int AVG_LOG  = 4,
   parameter int CODE_LAT = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [RES_W-1:0]            residue_i,
   input  logic [OUT_W-1:0]            uncorr_i,
   input  logic [2*NSEQ-1:0]           code_i,
   input  logic [QSH-1:0]              dither_i,
   input  logic                        freeze_i,
   output logic                        out_valid_o,
   output logic [OUT_W-1:0]            corr_o,
   output logic [NSEQ*(QSH+3)-1:0]     est_o
);
   localparam int EST_W = QSH + 3;
   localparam int SUM_W = EST_W + $clog2(NSEQ + 1) + 1;
   localparam int DW    = ((OUT_W > SUM_W) ? OUT_W : SUM_W) + 1;

   if (NSEQ < 1) begin : g_bad_nseq
      $error("dnc_canceller: NSEQ must be at least 1");
   end

   logic [2*NSEQ-1:0]       code_d;
   logic signed [2:0]       lvl;
   logic signed [EST_W-1:0] est   [NSEQ];
   logic signed [SUM_W-1:0] term  [NSEQ];
   logic signed [SUM_W-1:0] noise;
   logic signed [DW-1:0]    diff;

   dnc_code_delay #(.W(2*NSEQ), .LAT(CODE_LAT)) u_dly (
      .clk(clk), .rst_n(rst_n), .adv_i(in_valid),
      .code_i(code_i), .code_o(code_d));

   dnc_requant #(.RES_W(RES_W), .QSH(QSH)) u_rq (
      .clk(clk), .rst_n(rst_n), .res_i($signed(residue_i)),
      .dith_i(dither_i), .lvl_o(lvl));

   for (genvar k = 0; k < NSEQ; k++) begin : g_blk
      dnc_corr #(.QSH(QSH), .AVG_LOG(AVG_LOG), .EST_W(EST_W)) u_corr (
         .clk(clk), .rst_n(rst_n), .valid_i(in_valid), .freeze_i(freeze_i),
         .code_i(code_d[2*k +: 2]), .lvl_i(lvl), .est_o(est[k]));

      always_comb begin
         case (tern_e'(code_d[2*k +: 2]))
            TC_POS:  term[k] = SUM_W'(est[k]);
            TC_NEG:  term[k] = -SUM_W'(est[k]);
            default: term[k] = '0;
         endcase
      end

      assign est_o[k*EST_W +: EST_W] = est[k];
   end

   always_comb begin
      noise = '0;
      for (int k = 0; k < NSEQ; k++) noise = noise + term[k];
   end

   assign diff = DW'($signed(uncorr_i)) - DW'(noise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         corr_o      <= '0;
      end else begin
         out_valid_o <= in_valid;
         if (in_valid) corr_o <= diff[OUT_W-1:0];
      end
   end

   // R9: corrected word holds across idle cycles
   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(corr_o) && !out_valid_o));
endmodule

// File: tb/sim_dnc_canceller.sv
module sim_dnc_canceller;
   localparam int NS  = 9;
   localparam int RW  = 14;
   localparam int OW  = 16;
   localparam int QS  = 11;
   localparam int AL  = 4;
   localparam int LAT = 2;
   localparam int EW  = QS + 3;
   localparam int BLK = 1 << AL;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [RW-1:0] residue = '0;
   logic [OW-1:0] uncorr = '0;
   logic [2*NS-1:0] code = '0;
   logic [QS-1:0] dither = '0;
   logic freeze = 1'b0;
   logic out_valid;
   logic [OW-1:0] corr;
   logic [NS*EW-1:0] est;

   int checks = 0, failures = 0, cyc = 0;
   bit done = 0;

   int m_pipe [LAT][NS];
   int m_acc [NS], m_cnt [NS], m_est [NS];
   int m_out, m_ov;

   always #5 clk = ~clk;

   dnc_canceller #(.NSEQ(NS), .RES_W(RW), .OUT_W(OW), .QSH(QS),
                   .AVG_LOG(AL), .CODE_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .residue_i(residue),
      .uncorr_i(uncorr), .code_i(code), .dither_i(dither), .freeze_i(freeze),
      .out_valid_o(out_valid), .corr_o(corr), .est_o(est));

   function automatic int dec(input logic [1:0] c);   // R3 encoding
      if (c == 2'b01) return 1;
      if (c == 2'b11) return -1;
      return 0;
   endfunction

   function automatic int wrap(input int v);
      logic [OW-1:0] t = v[OW-1:0];
      return int'($signed(t));
   endfunction

   function automatic int est_of(input int k);
      logic [EW-1:0] t = est[k*EW +: EW];
      return int'($signed(t));
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < LAT; i++) for (int k = 0; k < NS; k++) m_pipe[i][k] = 0;
      for (int k = 0; k < NS; k++) begin m_acc[k] = 0; m_cnt[k] = 0; m_est[k] = 0; end
      m_out = 0; m_ov = 0;
   endtask

   task automatic model_step();
      int cur [NS];
      int q, s;
      if (in_valid) begin
         for (int k = 0; k < NS; k++) cur[k] = m_pipe[LAT-1][k];
         for (int i = LAT-1; i > 0; i--)
            for (int k = 0; k < NS; k++) m_pipe[i][k] = m_pipe[i-1][k];
         for (int k = 0; k < NS; k++) m_pipe[0][k] = dec(code[2*k +: 2]);
         q = (int'($signed(residue)) + int'(dither)) >>> QS;
         if (q > 3) q = 3;
         if (q < -3) q = -3;
         s = 0;
         for (int k = 0; k < NS; k++) s += cur[k] * m_est[k];
         m_out = wrap(int'($signed(uncorr)) - s);
         m_ov = 1;
         if (!freeze)
            for (int k = 0; k < NS; k++)
               if (cur[k] != 0) begin
                  m_acc[k] += cur[k] * q;
                  m_cnt[k]++;
                  if (m_cnt[k] == BLK) begin
                     m_est[k] = (m_acc[k] * (1 << QS)) >>> AL;
                     m_acc[k] = 0; m_cnt[k] = 0;
                  end
               end
      end else m_ov = 0;
   endtask

   task automatic compare();
      chk("R8 out_valid", int'(out_valid), m_ov);
      if (m_ov) chk("R8 corr", int'($signed(corr)), m_out);
      else      chk("R9 corr hold", int'($signed(corr)), m_out);
      for (int k = 0; k < NS; k++) chk("R6 estimate", est_of(k), m_est[k]);
   endtask

   // one clock: inputs already driven; model follows the rising edge
   task automatic tick();
      model_step();
      @(negedge clk);
      cyc++;
      compare();
   endtask

   task automatic drive(input bit v, input int res, input int unc,
                        input logic [2*NS-1:0] c, input int d, input bit f);
      in_valid = v; residue = RW'(res); uncorr = OW'(unc);
      code = c; dither = QS'(d); freeze = f;
      tick();
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 1'b0; freeze = 1'b0;
      repeat (3) @(negedge clk);
      model_reset();
      chk("R1 out_valid", int'(out_valid), 0);
      chk("R1 corr", int'(corr), 0);
      for (int k = 0; k < NS; k++) chk("R1 estimate", est_of(k), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      logic [2*NS-1:0] cB;
      do_reset();
      // block 0: +1, block 1: -1, block 2: alternate zero code, others zero
      cB = '0; cB[1:0] = 2'b01; cB[3:2] = 2'b11; cB[5:4] = 2'b10;
      for (int i = 0; i < 17; i++) begin
         drive(1, 4096, 0, cB, 0, 0);
         drive(0, 0, 0, {NS{2'b11}}, 0, 0);   // ignored codes while idle
      end
      chk("R4 alignment, one short of block", est_of(0), 0);
      drive(1, 4096, 0, cB, 0, 0);
      chk("R6 block estimate", est_of(0), 4096);
      chk("R3 negative code", est_of(1), -4096);
      chk("R3 alternate zero code", est_of(2), 0);
      chk("R5 zero code untouched", est_of(3), 0);
      drive(1, 0, 1000, cB, 0, 0);
      chk("R8 corrected word", int'($signed(corr)), -7192);

      do_reset();
      for (int i = 0; i < LAT + BLK; i++) drive(1, 8191, 0, cB, 2047, 0);
      chk("R2 clamp at +3", est_of(0), 6144);

      do_reset();
      for (int i = 0; i < 20; i++) drive(1, 4096, 0, cB, 0, 1);
      chk("R7 frozen estimate", est_of(0), 0);
      for (int i = 0; i < BLK; i++) drive(1, 4096, 0, cB, 0, 0);
      chk("R7 learning resumes", est_of(0), 4096);

      do_reset();
      for (int i = 0; i < 3000; i++) begin
         logic [2*NS-1:0] rc;
         for (int k = 0; k < NS; k++) rc[2*k +: 2] = 2'($urandom_range(0, 3));
         drive(($urandom_range(0, 3) != 0), int'($urandom_range(0, 16383)),
               int'($urandom_range(0, 65535)), rc, int'($urandom_range(0, 2047)),
               ($urandom_range(0, 9) == 0));
      end

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule